// File: doc/BRIEF.md
# Firmware Hub Nibble-Bus Write Target

This block is the target side of a single-byte memory write carried on a 4-bit multiplexed bus. A frame strobe (active low) marks the start of a transaction. The block samples the nibble bus on every rising clock edge and decides whether the transaction is a write meant for this device. To decide, it checks the start code, compares a device-select nibble with the strapped ID inputs and checks the size code. It collects a 28-bit address and a data byte, then waits through the host's turnaround cycle.

After that turnaround the block takes over the bus. It drives all ones for one cycle, then a ready-sync of zeros, then all ones again, and then lets the bus float. In the sync cycle it raises a one-cycle write strobe toward the storage array, with the collected address and data. The nibble bus is modelled as separate input and output vectors with an output-enable, so the pad ring can build the tri-state driver. A transaction takes 17 clocks, counting from the start nibble.

Top module: `fwh_write_target`

## Requirements
- R1: While reset is asserted, and after it is released with the frame strobe high, `bus_oe` and `wr_stb` stay low.
- R2: A transaction is accepted only if the start nibble sampled with `frame_n` low equals 4'b1101. With any other start code the block never raises `bus_oe` or `wr_stb` for that transaction.
- R3: If `frame_n` stays low for several clocks, only the nibble sampled in the last low cycle counts as the start code. Earlier nibbles have no effect.
- R4: The nibble in the first cycle after `frame_n` returns high is the device select. If it differs from `id_strap`, the block never drives the bus and never strobes for that transaction.
- R5: The next seven nibbles form the address, most significant first. The first carries bits 27:24 and the seventh carries bits 3:0. The address appears on `wr_addr` while `wr_stb` is high.
- R6: The nibble after the address is the size code. Only 4'b0000 is accepted; any other value ends the transaction with no bus drive and no strobe.
- R7: The two nibbles after the size code form the data byte, bits 3:0 first, then bits 7:4. The byte appears on `wr_data` while `wr_stb` is high.
- R8: Clocks are counted from the start nibble as clock 1. On an accepted transaction, `bus_oe` is low in clock 13. It is high in clocks 14, 15 and 16, with `bus_out` equal to 4'hF, 4'h0 and 4'hF. It is low again from clock 17.
- R9: `wr_stb` is high for exactly one clock, clock 15, the cycle in which the ready-sync 4'h0 is driven.
- R10: A low `frame_n` in any cycle abandons the current transaction. It drops `bus_oe` and blocks `wr_stb` in that same cycle, and that cycle is treated as a new start-code cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Frame strobe, active low |
| bus_in | input | 4 | Nibble sampled from the bus |
| id_strap | input | 4 | Strapped device identifier |
| bus_out | output | 4 | Nibble the device drives when enabled |
| bus_oe | output | 1 | Output enable for the nibble drivers |
| wr_stb | output | 1 | One-cycle write request to the array |
| wr_addr | output | 28 | Collected write address |
| wr_data | output | 8 | Collected write byte |

## Verification
A wrong state or nibble count inside the block always shows up at the ports on the same transaction, by clock 17 at the latest. It appears as `bus_oe` rising in the wrong cycle, the sync nibble landing off clock 15, or a strobe where none should be. A wrong shift order or an off-by-one in the address or data counter shows up as a wrong `wr_addr` or `wr_data` in the strobe cycle. Rejected transactions are caught by checking that the drivers stay off through all 17 clocks.

// File: rtl/fwh_write_target.sv
module fwh_write_target #(
  parameter int         NIB          = 4,
  parameter int         ADDR_NIBBLES = 7,
  parameter int         DATA_NIBBLES = 2,
  parameter logic [3:0] START_WR     = 4'b1101,
  parameter logic [3:0] SIZE_ONE     = 4'b0000,
  parameter logic [3:0] SYNC_READY   = 4'b0000,
  parameter logic [3:0] TAR_LEVEL    = 4'b1111
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_n,
  input  logic [NIB-1:0]              bus_in,
  input  logic [NIB-1:0]              id_strap,
  output logic [NIB-1:0]              bus_out,
  output logic                        bus_oe,
  output logic                        wr_stb,
  output logic [NIB*ADDR_NIBBLES-1:0] wr_addr,
  output logic [NIB*DATA_NIBBLES-1:0] wr_data
);

  localparam int AW   = NIB * ADDR_NIBBLES;
  localparam int DW   = NIB * DATA_NIBBLES;
  localparam int MAXN = (ADDR_NIBBLES > DATA_NIBBLES) ? ADDR_NIBBLES : DATA_NIBBLES;
  localparam int CW   = $clog2(MAXN + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_ADDR, S_SIZE, S_DATA, S_HTAR, S_DTAR, S_SYNC, S_REL
  } state_t;

  state_t        state;
  logic          start_ok;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          drive_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      start_ok <= 1'b0;
      cnt      <= '0;
      addr_q   <= '0;
      data_q   <= '0;
    end else if (!frame_n) begin
      state    <= S_SEL;
      start_ok <= (bus_in == START_WR);
      cnt      <= '0;
    end else begin
      case (state)
        S_SEL: begin
          cnt   <= '0;
          state <= (start_ok && bus_in == id_strap) ? S_ADDR : S_IDLE;
        end
        S_ADDR: begin
          addr_q <= {addr_q[AW-NIB-1:0], bus_in};
          if (cnt == CW'(ADDR_NIBBLES - 1)) begin
            cnt   <= '0;
            state <= S_SIZE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SIZE:
          state <= (bus_in == SIZE_ONE) ? S_DATA : S_IDLE;
        S_DATA: begin
          data_q <= {bus_in, data_q[DW-1:NIB]};
          if (cnt == CW'(DATA_NIBBLES - 1)) begin
            cnt   <= '0;
            state <= S_HTAR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HTAR:  state <= S_DTAR;
        S_DTAR:  state <= S_SYNC;
        S_SYNC:  state <= S_REL;
        S_REL:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign drive_phase = (state == S_DTAR) || (state == S_SYNC) || (state == S_REL);
  assign bus_oe      = frame_n && drive_phase;
  assign bus_out     = (state == S_SYNC) ? SYNC_READY : TAR_LEVEL;
  assign wr_stb      = frame_n && (state == S_SYNC);
  assign wr_addr     = addr_q;
  assign wr_data     = data_q;

endmodule

module fwh_write_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] bus_out,
  input logic       bus_oe,
  input logic       wr_stb
);

  AST_STB_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (bus_oe && bus_out == 4'h0)); // R9

  AST_SYNC_GIVES_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && bus_out == 4'h0) |-> wr_stb); // R9

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R9

  AST_DRIVE_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(bus_oe)); // R8

  AST_FIRST_DRIVE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> bus_out == 4'hF); // R8

  AST_RELEASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_stb) && frame_n) |-> (bus_oe && bus_out == 4'hF)); // R8

endmodule

bind fwh_write_target fwh_write_target_chk i_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n),
  .bus_out(bus_out), .bus_oe(bus_oe), .wr_stb(wr_stb)
);

// File: tb/test_fwh_write_target.sv
module test_fwh_write_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  id_strap = 4'hA;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic        wr_stb;
  logic [27:0] wr_addr;
  logic [7:0]  wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fwh_write_target i_fwh_write_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
    .id_strap(id_strap), .bus_out(bus_out), .bus_oe(bus_oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit accepts(input logic [3:0] st, input logic [3:0] idv,
                                 input logic [3:0] sz);
    return st == 4'b1101 && idv == id_strap && sz == 4'b0000;
  endfunction

  function automatic logic [3:0] nib_at(input int k, input logic [3:0] idv,
      input logic [27:0] a, input logic [3:0] sz, input logic [7:0] d);
    if (k == 2) return idv;
    if (k >= 3 && k <= 9) return a[27-4*(k-3) -: 4];
    if (k == 10) return sz;
    if (k == 11) return d[3:0];
    if (k == 12) return d[7:4];
    if (k == 13) return 4'hF;
    return 4'($urandom);
  endfunction

  task automatic step(input logic fr, input logic [3:0] nb, input bit e_oe,
                      input logic [3:0] e_out, input bit e_stb, input string req);
    @(negedge clk);
    frame_n = fr;
    bus_in  = nb;
    #1;
    chk(bus_oe == e_oe, req, "bus_oe", 32'(bus_oe), 32'(e_oe));
    if (e_oe) chk(bus_out == e_out, req, "bus_out", 32'(bus_out), 32'(e_out));
    chk(wr_stb == e_stb, req, "wr_stb", 32'(wr_stb), 32'(e_stb));
  endtask

  task automatic run_txn(input int npre, input logic [3:0] pre0, input logic [3:0] pre1,
                         input logic [3:0] st, input logic [3:0] idv,
                         input logic [27:0] a, input logic [3:0] sz,
                         input logic [7:0] d, input int abort_clk);
    bit resp;
    string rq;
    resp = accepts(st, idv, sz);
    rq   = resp ? "R8" : "R2 R3 R4 R6 no-response";
    if (npre > 0) step(1'b0, pre0, 1'b0, 4'hF, 1'b0, "R3 R10");
    if (npre > 1) step(1'b0, pre1, 1'b0, 4'hF, 1'b0, "R3 R10");
    step(1'b0, st, 1'b0, 4'hF, 1'b0, "R2");
    for (int k = 2; k <= 17; k++) begin
      if (k == abort_clk) begin
        step(1'b0, 4'hD, 1'b0, 4'hF, 1'b0, "R10 abort");
        return;
      end
      step(1'b1, nib_at(k, idv, a, sz, d), resp && k >= 14 && k <= 16,
           (k == 15) ? 4'h0 : 4'hF, resp && k == 15, (k == 15) ? "R9" : rq);
      if (resp && k == 15) begin
        chk(wr_addr == a, "R5", "wr_addr", 32'(wr_addr), 32'(a));
        chk(wr_data == d, "R7", "wr_data", 32'(wr_data), 32'(d));
      end
    end
    for (int g = 0; g < 2; g++) step(1'b1, 4'($urandom), 1'b0, 4'hF, 1'b0, "R10 idle");
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(bus_oe == 1'b0, "R1", "bus_oe in reset", 32'(bus_oe), 0);
    chk(wr_stb == 1'b0, "R1", "wr_stb in reset", 32'(wr_stb), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 4'($urandom), 1'b0, 4'hF, 1'b0, "R1");

    run_txn(0, 0, 0, 4'hD, 4'hA, 28'hABCDEF1, 4'h0, 8'h5A, 0);
    run_txn(0, 0, 0, 4'hD, 4'hA, 28'h0000000, 4'h0, 8'hFF, 0);
    run_txn(0, 0, 0, 4'hD, 4'hA, 28'hFFFFFFF, 4'h0, 8'h00, 0);
    run_txn(0, 0, 0, 4'hD, 4'hA, 28'h8000001, 4'h0, 8'h81, 0);
    run_txn(1, 4'hD, 0, 4'h0, 4'hA, 28'h1234567, 4'h0, 8'h11, 0);     // R3 last code bad
    run_txn(2, 4'h0, 4'h5, 4'hD, 4'hA, 28'h7654321, 4'h0, 8'h22, 0);  // R3 last code good
    run_txn(0, 0, 0, 4'hC, 4'hA, 28'h1111111, 4'h0, 8'h33, 0);        // R2
    run_txn(0, 0, 0, 4'hD, 4'h5, 28'h2222222, 4'h0, 8'h44, 0);        // R4
    run_txn(0, 0, 0, 4'hD, 4'hA, 28'h3333333, 4'h1, 8'h55, 0);        // R6
    run_txn(0, 0, 0, 4'hD, 4'hA, 28'h4444444, 4'h8, 8'h66, 0);        // R6
    run_txn(0, 0, 0, 4'hD, 4'hA, 28'h5555555, 4'h0, 8'h77, 6);        // R10
    run_txn(0, 0, 0, 4'hD, 4'hA, 28'h6666666, 4'h0, 8'h88, 14);       // R10
    run_txn(0, 0, 0, 4'hD, 4'hA, 28'h7777777, 4'h0, 8'h99, 15);       // R10
    run_txn(0, 0, 0, 4'hD, 4'hA, 28'h0F0F0F0, 4'h0, 8'hC3, 0);

    for (int t = 0; t < 80; t++) begin
      logic [3:0] idv, st, sz;
      int np, ab;
      id_strap = 4'($urandom);
      idv = ($urandom % 10 < 7) ? id_strap : 4'($urandom);
      st  = ($urandom % 10 < 8) ? 4'hD : 4'($urandom);
      sz  = ($urandom % 10 < 8) ? 4'h0 : 4'($urandom);
      np  = int'($urandom % 3);
      ab  = ($urandom % 8 == 0) ? int'(2 + $urandom % 16) : 0;
      run_txn(np, 4'($urandom), 4'($urandom), st, idv, 28'($urandom), sz,
              8'($urandom), ab);
    end
    run_txn(0, 0, 0, 4'hD, id_strap, 28'h0A5A5A5, 4'h0, 8'h3C, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule